// File: doc/BRIEF.md
# Configuration and Startup Sequencer

This block brings a programmable logic device from an unconfigured state to running user logic. It works in three phases, always in the same order. First it wipes configuration memory for a fixed number of clock cycles. Then it accepts configuration words from a stream. Finally it runs a short startup ramp that lets go of the device-wide control signals one stage at a time.

A power-on request or a program request, sampled at any clock edge, starts the flow over from the wipe phase. When power-on reset drops, the flow runs with no further action. The block drives its own init line low during the wipe. An outside agent that keeps the shared init line low (reported on `init_ext_low`) holds the block at the gate before loading.

Configuration words arrive on a valid/ready stream. `in_ready` is high only in the load phase. A word is taken on any edge where `in_valid` and `in_ready` are both high. A sender that sees `in_ready` low must hold its word. The accepted word appears for one cycle on the `wr_valid`/`wr_data` port toward the memory array, which has no back-pressure.

Top module: `cfg_seq_top`

## Requirements
- R1: If `por_req` or `prog_req` is high at a clock edge, then after that edge `init_o` is 0, `done_o` is 0, `hold_tristate`, `hold_reset` and `hold_write` are 1, and `clr_strobe` is 1. This applies in every phase.
- R2: The wipe phase lasts exactly CLEAR_CYCLES clock cycles, counting the cycle after the request edge. `clr_strobe` is 1 and `init_o` is 0 during all of it. A new request during the wipe restarts the full count.
- R3: When the wipe ends, `init_o` goes to 1 and `clr_strobe` goes to 0. The load phase (`in_ready` = 1) begins on the edge after `init_ext_low` is first sampled 0. While `init_ext_low` stays 1, `in_ready` stays 0.
- R4: `in_ready` is 1 only in the load phase. A word taken at an edge shows on `wr_data`, with `wr_valid` = 1, right after that edge. A word offered outside the load phase, or after a request edge, leaves `wr_valid` at 0.
- R5: In the load phase, `load_done` = 1 at an edge ends loading. A word presented at that same edge is still taken. After that edge, `done_o` is 1, `in_ready` is 0, and `hold_tristate` is still 1.
- R6: One clock after `done_o` rises, `hold_tristate` goes to 0 while `hold_reset` and `hold_write` stay at 1.
- R7: One clock after `hold_tristate` falls, `hold_reset` and `hold_write` both go to 0 on the same edge. The block then stays in this running state until a request arrives.
- R8: Whenever `done_o` is 0, all three hold outputs are 1. `hold_reset` always equals `hold_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock |
| por_req | input | 1 | Power-on reset request, synchronous, active high |
| prog_req | input | 1 | Program (restart) request, synchronous, active high |
| init_ext_low | input | 1 | Shared init line is being held low from outside |
| in_valid | input | 1 | Configuration word offered |
| in_ready | output | 1 | Block takes words (load phase only) |
| in_data | input | DATA_W | Configuration word |
| load_done | input | 1 | Last word delivered; begin startup |
| wr_valid | output | 1 | Accepted word forwarded to the memory array |
| wr_data | output | DATA_W | Forwarded word |
| init_o | output | 1 | Block's init driver (0 while wiping) |
| done_o | output | 1 | Configuration and startup reached |
| clr_strobe | output | 1 | Memory wipe in progress |
| hold_tristate | output | 1 | 1 = device outputs kept in high impedance |
| hold_reset | output | 1 | 1 = device-wide set/reset held |
| hold_write | output | 1 | 1 = device-wide write enable blocked |

## Verification
The hardest case to reach is a restart that lands deep inside a phase. Examples are a program request midway through the wipe count, or one in the same cycle a word is offered during loading. A request that lands on a phase boundary would hide a counter that fails to clear or a forwarding register that leaks a word. The stimulus places each request at a chosen cycle offset within its phase. It then counts the full wipe length again from that point and confirms that no stale word comes out.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_WAIT  = 3'd1,
    ST_LOAD  = 3'd2,
    ST_DONE  = 3'd3,
    ST_GTS   = 3'd4,
    ST_RUN   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
  parameter int CLEAR_CYCLES = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int CW = (CLEAR_CYCLES < 2) ? 1 : $clog2(CLEAR_CYCLES);
  localparam logic [CW-1:0] LAST_VAL = CW'(CLEAR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)                       cnt <= '0;
    else if (en && cnt != LAST_VAL) cnt <= cnt + 1'b1;
  end

  assign last = en && (cnt == LAST_VAL);
endmodule

// File: rtl/cfg_load_port.sv
module cfg_load_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);
  logic take;

  assign in_ready = open;
  assign take     = open && in_valid && !rst;

  always_ff @(posedge clk) begin
    if (rst) wr_valid <= 1'b0;
    else     wr_valid <= take;
    if (take) wr_data <= in_data;
  end
endmodule

// File: rtl/cfg_release_ctl.sv
module cfg_release_ctl
  import cfg_seq_pkg::*;
(
  input  seq_state_e st,
  output logic       init_o,
  output logic       done_o,
  output logic       clr_strobe,
  output logic       hold_tristate,
  output logic       hold_reset,
  output logic       hold_write
);
  always_comb begin
    clr_strobe    = (st == ST_CLEAR);
    init_o        = (st != ST_CLEAR);
    done_o        = (st == ST_DONE) || (st == ST_GTS) || (st == ST_RUN);
    hold_tristate = !((st == ST_GTS) || (st == ST_RUN));
    hold_reset    = (st != ST_RUN);
    hold_write    = (st != ST_RUN);
  end
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CLEAR_CYCLES = 16
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              prog_req,
  input  logic              init_ext_low,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              load_done,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              init_o,
  output logic              done_o,
  output logic              clr_strobe,
  output logic              hold_tristate,
  output logic              hold_reset,
  output logic              hold_write
);
  seq_state_e st, st_nx;
  logic       restart;
  logic       clear_last;

  assign restart = por_req || prog_req;

  cfg_clear_timer #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_timer (
    .clk  (clk),
    .clr  (restart || st != ST_CLEAR),
    .en   (st == ST_CLEAR),
    .last (clear_last)
  );

  cfg_load_port #(.DATA_W(DATA_W)) u_port (
    .clk      (clk),
    .rst      (restart),
    .open     (st == ST_LOAD),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .wr_valid (wr_valid),
    .wr_data  (wr_data)
  );

  cfg_release_ctl u_rel (
    .st            (st),
    .init_o        (init_o),
    .done_o        (done_o),
    .clr_strobe    (clr_strobe),
    .hold_tristate (hold_tristate),
    .hold_reset    (hold_reset),
    .hold_write    (hold_write)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_CLEAR: if (clear_last)    st_nx = ST_WAIT;
      ST_WAIT:  if (!init_ext_low) st_nx = ST_LOAD;
      ST_LOAD:  if (load_done)     st_nx = ST_DONE;
      ST_DONE:                     st_nx = ST_GTS;
      ST_GTS:                      st_nx = ST_RUN;
      ST_RUN:                      st_nx = ST_RUN;
      default:                     st_nx = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (restart) st <= ST_CLEAR;
    else         st <= st_nx;
  end
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              por_req,
  input logic              prog_req,
  input logic              init_ext_low,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              load_done,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              init_o,
  input logic              done_o,
  input logic              clr_strobe,
  input logic              hold_tristate,
  input logic              hold_reset,
  input logic              hold_write
);
  logic req;
  assign req = por_req || prog_req;

  AST_REQ_RESTARTS: assert property (@(posedge clk) req |=> (!init_o && !done_o && clr_strobe && hold_tristate && hold_reset && hold_write)); // R1
  AST_CLEAR_INIT_LOW: assert property (@(posedge clk) disable iff (por_req) clr_strobe |-> (!init_o && !in_ready)); // R2
  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (req) (init_o && !in_ready && !done_o && init_ext_low) |=> !in_ready); // R3
  AST_WORD_FORWARDED: assert property (@(posedge clk) disable iff (req) (in_valid && in_ready) |=> (wr_valid && wr_data == $past(in_data))); // R4
  AST_NO_STRAY_WORD: assert property (@(posedge clk) (req || !(in_valid && in_ready)) |=> !wr_valid); // R4
  AST_DONE_FIRST: assert property (@(posedge clk) disable iff (req) (in_ready && load_done) |=> (done_o && hold_tristate && !in_ready)); // R5
  AST_TRISTATE_STAGE: assert property (@(posedge clk) disable iff (req) (done_o && hold_tristate) |=> (!hold_tristate && hold_reset && done_o)); // R6
  AST_RESET_STAGE: assert property (@(posedge clk) disable iff (req) (done_o && !hold_tristate && hold_reset) |=> (!hold_reset && !hold_write)); // R7
  AST_HELD_UNCONFIG: assert property (@(posedge clk) disable iff (por_req) !done_o |-> (hold_tristate && hold_reset && hold_write)); // R8
  AST_RESET_WRITE_PAIR: assert property (@(posedge clk) disable iff (por_req) hold_reset == hold_write); // R8
endmodule

bind cfg_seq_top cfg_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .por_req       (por_req),
  .prog_req      (prog_req),
  .init_ext_low  (init_ext_low),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_data       (in_data),
  .load_done     (load_done),
  .wr_valid      (wr_valid),
  .wr_data       (wr_data),
  .init_o        (init_o),
  .done_o        (done_o),
  .clr_strobe    (clr_strobe),
  .hold_tristate (hold_tristate),
  .hold_reset    (hold_reset),
  .hold_write    (hold_write)
);

// File: tb/tb_cfg_seq_top.sv
module tb_cfg_seq_top;
  localparam int DW  = 8;
  localparam int CLR = 3;

  logic clk = 1'b0;
  logic por_req = 1'b1, prog_req = 1'b0, init_ext_low = 1'b0;
  logic in_valid = 1'b0, load_done = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, wr_valid, init_o, done_o, clr_strobe;
  logic hold_tristate, hold_reset, hold_write;
  logic [DW-1:0] wr_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cfg_seq_top #(.DATA_W(DW), .CLEAR_CYCLES(CLR)) dut (
    .clk(clk), .por_req(por_req), .prog_req(prog_req), .init_ext_low(init_ext_low),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .load_done(load_done),
    .wr_valid(wr_valid), .wr_data(wr_data), .init_o(init_o), .done_o(done_o),
    .clr_strobe(clr_strobe), .hold_tristate(hold_tristate), .hold_reset(hold_reset),
    .hold_write(hold_write)
  );

  // exp bits: {init, done, tristate, reset, write, clr, ready, wvalid}
  typedef struct packed {
    logic por; logic prog; logic ext; logic vld; logic [7:0] d; logic ld;
    logic [7:0] e; logic [7:0] ed;
  } vec_t;

  localparam logic [7:0] E_CLR  = 8'b0011_1100;
  localparam logic [7:0] E_WAIT = 8'b1011_1000;
  localparam logic [7:0] E_LOAD = 8'b1011_1010;

  localparam vec_t TBL [14] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, E_CLR,        8'h00}, // R1 reset
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, E_CLR,        8'h00}, // R2
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 1'b0, E_CLR,        8'h00}, // R4 ignored in clear
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, E_WAIT,       8'h00}, // R2 length, R3
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'hBB, 1'b0, E_WAIT,       8'h00}, // R3 gate held
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, E_LOAD,       8'h00}, // R3 gate opens
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, E_LOAD | 8'h01, 8'h5A}, // R4
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b0, E_LOAD | 8'h01, 8'hC3}, // R4
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, E_LOAD,       8'h00}, // R4
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h0F, 1'b1, 8'b1111_1001, 8'h0F}, // R5
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 8'b1101_1000, 8'h00}, // R6, R4 ignored
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'b1100_0000, 8'h00}, // R7
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'b1100_0000, 8'h00}, // R7 stays
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, E_CLR,        8'h00}  // R1 restart
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {init_o, done_o, hold_tristate, hold_reset, hold_write, clr_strobe, in_ready, wr_valid};
  endfunction

  task automatic drive(input logic po, input logic pg, input logic ex,
                       input logic vl, input logic [7:0] dd, input logic ld);
    por_req = po; prog_req = pg; init_ext_low = ex;
    in_valid = vl; in_data = dd; load_done = ld;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5;
    for (int i = 0; i < 14; i++) begin
      drive(TBL[i].por, TBL[i].prog, TBL[i].ext, TBL[i].vld, TBL[i].d, TBL[i].ld);
      step();
      chk($sformatf("R1-table row %0d outputs (R2 R3 R4 R5 R6 R7 R8)", i), outs(), TBL[i].e);
      if (TBL[i].e[0]) chk("R4 forwarded word", wr_data, TBL[i].ed);
    end

    // R2: restart in the middle of the wipe restarts the full count
    drive(0, 0, 0, 0, 8'h00, 0);
    step();                                   // clear count 1
    drive(0, 1, 0, 0, 8'h00, 0);
    step();                                   // restart: count 0
    drive(0, 0, 0, 0, 8'h00, 0);
    for (int k = 1; k < CLR; k++) begin
      step();
      chk("R2 wipe still running after mid-clear restart", outs(), E_CLR);
    end
    step();
    chk("R2 wipe ended after full count", outs(), E_WAIT);
    step();
    chk("R3 load opens with init released", outs(), E_LOAD);

    // R4: program request in the same cycle as an offered word drops it
    drive(0, 1, 0, 1, 8'h99, 0);
    step();
    chk("R4 word offered at request edge not forwarded", outs(), E_CLR);

    // R1/R8: power-on request during startup ramp
    drive(0, 0, 0, 0, 8'h00, 0);
    for (int k = 0; k < CLR; k++) step();
    step();                                   // load
    drive(0, 0, 0, 0, 8'h00, 1);
    step();
    chk("R5 done rises with tristate held", outs(), 8'b1111_1000);
    drive(1, 0, 0, 0, 8'h00, 0);
    step();
    chk("R1 power-on request aborts startup", outs(), E_CLR);
    chk("R8 holds while unconfigured", {5'b0, hold_tristate, hold_reset, hold_write}, 8'h07);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule